// File: doc/BRIEF.md
# Configuration-Space Serial EEPROM Port

This block lets host software drive a three-wire serial configuration EEPROM by bit-banging it through configuration-space accesses. Two otherwise unused configuration offsets carry the pin controls. A write to the select offset raises chip-select and loads the clock and data-in lines from two bits of the write data. A write to the release offset drops all three lines. The EEPROM's data-out line is read back through a one-byte configuration read at offset zero. When data-out is low, the low byte of the normal read value is forced to zero. Every other configuration write is passed through to the normal configuration logic.

The block also holds an image checker. It is fed a 64-word EEPROM image one word per cycle and accumulates a wrap-around 16-bit sum. After the last word it raises a valid flag, and it raises a pass flag when the sum equals the fixed target 0x1234. Each word is built from a byte pair with the low byte first. The image's checksum word sits at byte offsets 126 and 127, so software can fill it in to make any image pass.

The reset input is asynchronous and active low. The block releases it internally through a two-stage synchroniser, so its registers leave reset on the second rising clock edge after the reset input goes high.

Top module: `cfg_eeprom_port`

## Requirements
- R1: A write (`cfg_wr` high) at offset 0x80 sets `ee_cs` to 1, `ee_sk` to `cfg_wdata` bit 7 and `ee_di` to `cfg_wdata` bit 6, visible from the next clock cycle.
- R2: A write at offset 0xC0 sets `ee_cs`, `ee_sk` and `ee_di` all to 0, visible from the next clock cycle.
- R3: In any cycle without a write to 0x80 or 0xC0, including writes to other offsets, the three pin outputs keep their previous values.
- R4: When `cfg_addr` is 0x00, `cfg_size` is 1 and `ee_do` is 0, `cfg_rdata` equals `cfg_dflt_rdata` with bits 7:0 forced to 0. In every other case `cfg_rdata` equals `cfg_dflt_rdata`. The output is combinational, in the same cycle.
- R5: `cfg_pass_wr` is high in the same cycle as a write to any offset other than 0x80 and 0xC0. It is low for writes to those two offsets and when there is no write.
- R6: `img_start` clears the word count, the sum, `img_valid` and `img_pass`, and a word offered in that same cycle is dropped. Otherwise, each cycle with `img_word_vld` high adds `img_word` to the sum modulo 2^16, until 64 words have been taken.
- R7: `img_valid` goes high in the cycle after the 64th word is accepted. Further words are ignored and leave both flags unchanged until the next `img_start`.
- R8: `img_pass` goes high together with `img_valid` exactly when the 16-bit sum of the 64 words equals 0x1234. A default image passes: bytes 0x57,0x00 repeated over bytes 0..31, 7 at byte 64, 0x0F at byte 65, 4 at byte 67, 0x07 at byte 68, zeros elsewhere, and checksum word = 0x1234 minus the sum of the other 63 words, stored low byte at 126 and high byte at 127. The same image with one changed byte fails.
- R9: During reset and until the second rising edge after release, `ee_cs`, `ee_sk`, `ee_di`, `img_valid` and `img_pass` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Configuration byte offset of the access |
| cfg_size | input | 3 | Access size in bytes (1, 2 or 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_dflt_rdata | input | 32 | Read data from the normal configuration logic |
| cfg_rdata | output | 32 | Read data after data-out gating |
| cfg_pass_wr | output | 1 | Write strobe forwarded to normal configuration logic |
| ee_cs | output | 1 | EEPROM chip-select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data toward the device |
| ee_do | input | 1 | EEPROM serial data from the device |
| img_start | input | 1 | Clears the image checker |
| img_word_vld | input | 1 | An image word is offered this cycle |
| img_word | input | 16 | Image word, low byte in bits 7:0 |
| img_valid | output | 1 | All 64 words have been summed |
| img_pass | output | 1 | Sum matched the target |

## Verification
A pin register that is loaded from the wrong write, or from the wrong data bit, is visible on the pins one cycle after the write. A faulty hold path is visible as soon as any unrelated write goes by, so the comparison on every clock catches it within a cycle. A wrong word count or a wrong sum register in the checker does not show until the flags are due. The bench therefore runs complete images and checks the flags in the exact cycle after the 64th word: a passing default image, a corrupted image, an image whose sum wraps, a restart partway through an image, and surplus words after completion.

// File: rtl/cfg_eeprom_pkg.sv
package cfg_eeprom_pkg;
  parameter int CFG_AW = 8;
  parameter int CFG_DW = 32;
  parameter int IMG_WORDS = 64;
  parameter int WORD_W = 16;

  localparam logic [CFG_AW-1:0] OFS_PIN_SEL = 8'h80;
  localparam logic [CFG_AW-1:0] OFS_PIN_REL = 8'hC0;
  localparam logic [CFG_AW-1:0] OFS_DO_RD   = 8'h00;
  localparam logic [WORD_W-1:0] SUM_TARGET  = 16'h1234;
  localparam int SK_BIT = 7;
  localparam int DI_BIT = 6;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } ee_pins_t;
endpackage

// File: rtl/ee_pin_ctrl.sv
module ee_pin_ctrl
  import cfg_eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic              rel_wr,
  input  logic              sk_in,
  input  logic              di_in,
  output ee_pins_t          pins
);
  ee_pins_t pins_q, pins_d;
  logic     pins_en;

  always_comb begin
    pins_en = sel_wr | rel_wr;
    pins_d  = '0;
    if (sel_wr) begin
      pins_d.cs = 1'b1;
      pins_d.sk = sk_in;
      pins_d.di = di_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pins_q <= '0;
    else if (pins_en) pins_q <= pins_d;
  end

  assign pins = pins_q;
endmodule

// File: rtl/cfg_rd_gate.sv
module cfg_rd_gate
  import cfg_eeprom_pkg::*;
(
  input  logic [CFG_AW-1:0] addr,
  input  logic [2:0]        size,
  input  logic              do_in,
  input  logic [CFG_DW-1:0] dflt,
  output logic [CFG_DW-1:0] rdata
);
  logic gate_low;

  always_comb begin
    gate_low = (addr == OFS_DO_RD) && (size == 3'd1) && !do_in;
    rdata    = dflt;
    if (gate_low) rdata[7:0] = 8'h00;
  end
endmodule

// File: rtl/ee_img_sum.sv
module ee_img_sum
  import cfg_eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic              valid,
  output logic              pass
);
  localparam int CNT_W = $clog2(IMG_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IMG_WORDS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(IMG_WORDS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] acc_q, acc_d, acc_sum;
  logic              valid_q, valid_d, pass_q, pass_d;
  logic              take, st_en;

  always_comb begin
    acc_sum = acc_q + word;
    take    = word_vld && (cnt_q != FULL);
    st_en   = start | take;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    valid_d = valid_q;
    pass_d  = pass_q;
    if (start) begin
      cnt_d   = '0;
      acc_d   = '0;
      valid_d = 1'b0;
      pass_d  = 1'b0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = acc_sum;
      if (cnt_q == LAST) begin
        valid_d = 1'b1;
        pass_d  = (acc_sum == SUM_TARGET);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else if (st_en) begin
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      valid_q <= valid_d;
      pass_q  <= pass_d;
    end
  end

  assign valid = valid_q;
  assign pass  = pass_q;
endmodule

// File: rtl/cfg_eeprom_port.sv
module cfg_eeprom_port
  import cfg_eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [2:0]        cfg_size,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              cfg_wr,
  input  logic [CFG_DW-1:0] cfg_dflt_rdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              cfg_pass_wr,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do,
  input  logic              img_start,
  input  logic              img_word_vld,
  input  logic [WORD_W-1:0] img_word,
  output logic              img_valid,
  output logic              img_pass
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       sel_wr, rel_wr;
  ee_pins_t   pins;
  logic       unused_wdata_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    sel_wr      = cfg_wr && (cfg_addr == OFS_PIN_SEL);
    rel_wr      = cfg_wr && (cfg_addr == OFS_PIN_REL);
    cfg_pass_wr = cfg_wr && !sel_wr && !rel_wr;
  end

  assign unused_wdata_bits = ^{cfg_wdata[CFG_DW-1:SK_BIT+1], cfg_wdata[DI_BIT-1:0]};

  ee_pin_ctrl u_pins (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sel_wr (sel_wr),
    .rel_wr (rel_wr),
    .sk_in  (cfg_wdata[SK_BIT]),
    .di_in  (cfg_wdata[DI_BIT]),
    .pins   (pins)
  );

  assign ee_cs = pins.cs;
  assign ee_sk = pins.sk;
  assign ee_di = pins.di;

  cfg_rd_gate u_gate (
    .addr  (cfg_addr),
    .size  (cfg_size),
    .do_in (ee_do),
    .dflt  (cfg_dflt_rdata),
    .rdata (cfg_rdata)
  );

  ee_img_sum u_sum (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (img_start),
    .word_vld (img_word_vld),
    .word     (img_word),
    .valid    (img_valid),
    .pass     (img_pass)
  );
endmodule

// File: rtl/cfg_eeprom_port_chk.sv
module cfg_eeprom_port_chk
  import cfg_eeprom_pkg::*;
(
  input logic              clk,
  input logic              rst_int_n,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_wdata,
  input logic              cfg_wr,
  input logic              cfg_pass_wr,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di,
  input logic              img_start,
  input logic              img_word_vld,
  input logic              img_valid,
  input logic              img_pass
);
  // R1
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_wr && cfg_addr == OFS_PIN_SEL) |=>
      (ee_cs && ee_sk == $past(cfg_wdata[SK_BIT]) && ee_di == $past(cfg_wdata[DI_BIT])));

  // R2
  rel_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_wr && cfg_addr == OFS_PIN_REL) |=> (!ee_cs && !ee_sk && !ee_di));

  // R3
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cfg_wr && (cfg_addr == OFS_PIN_SEL || cfg_addr == OFS_PIN_REL)) |=>
      $stable({ee_cs, ee_sk, ee_di}));

  // R5
  pin_wr_not_passed_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_addr == OFS_PIN_SEL || cfg_addr == OFS_PIN_REL || !cfg_wr) |-> !cfg_pass_wr);

  // R7
  valid_after_word_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(img_valid) |-> ($past(img_word_vld) && !$past(img_start)));

  // R6
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    img_start |=> (!img_valid && !img_pass));

  // R8
  pass_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    img_pass |-> img_valid);
endmodule

bind cfg_eeprom_port cfg_eeprom_port_chk u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .cfg_wr       (cfg_wr),
  .cfg_pass_wr  (cfg_pass_wr),
  .ee_cs        (ee_cs),
  .ee_sk        (ee_sk),
  .ee_di        (ee_di),
  .img_start    (img_start),
  .img_word_vld (img_word_vld),
  .img_valid    (img_valid),
  .img_pass     (img_pass)
);

// File: tb/cfg_eeprom_port_test.sv
module cfg_eeprom_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = 8'h10;
  logic [2:0]  cfg_size = 3'd4;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_dflt_rdata = 32'hA5C3_1F7E;
  logic [31:0] cfg_rdata;
  logic        cfg_pass_wr;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b1;
  logic        img_start = 1'b0;
  logic        img_word_vld = 1'b0;
  logic [15:0] img_word = '0;
  logic        img_valid, img_pass;

  int checks = 0;
  int fails = 0;

  // reference model state
  int   rel_cycles = 0;
  bit   m_cs, m_sk, m_di, m_valid, m_pass;
  int   m_cnt;
  int   m_acc;

  always #5 clk = ~clk;

  cfg_eeprom_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_dflt_rdata(cfg_dflt_rdata),
    .cfg_rdata(cfg_rdata), .cfg_pass_wr(cfg_pass_wr), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do), .img_start(img_start),
    .img_word_vld(img_word_vld), .img_word(img_word), .img_valid(img_valid),
    .img_pass(img_pass)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cycles = 0;
      m_cs = 0; m_sk = 0; m_di = 0; m_valid = 0; m_pass = 0; m_cnt = 0; m_acc = 0;
    end else if (rel_cycles < 2) begin
      rel_cycles++;
      m_cs = 0; m_sk = 0; m_di = 0; m_valid = 0; m_pass = 0; m_cnt = 0; m_acc = 0;
    end else begin
      if (cfg_wr && cfg_addr == 8'h80) begin
        m_cs = 1; m_sk = cfg_wdata[7]; m_di = cfg_wdata[6];
      end else if (cfg_wr && cfg_addr == 8'hC0) begin
        m_cs = 0; m_sk = 0; m_di = 0;
      end
      if (img_start) begin
        m_cnt = 0; m_acc = 0; m_valid = 0; m_pass = 0;
      end else if (img_word_vld && m_cnt < 64) begin
        m_acc = (m_acc + img_word) % 65536;
        m_cnt++;
        if (m_cnt == 64) begin
          m_valid = 1;
          m_pass = (m_acc == 'h1234);
        end
      end
    end
  end

  task automatic check1(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    bit exp_pw;
    exp_rd = cfg_dflt_rdata;
    if (cfg_addr == 8'h00 && cfg_size == 3'd1 && !ee_do) exp_rd[7:0] = 8'h00;
    exp_pw = cfg_wr && cfg_addr != 8'h80 && cfg_addr != 8'hC0;
    if (!rst_n || rel_cycles < 2) begin
      check1("R9 reset pins", {ee_cs, ee_sk, ee_di}, 0);
      check1("R9 reset flags", {img_valid, img_pass}, 0);
    end else begin
      check1("R1/R2/R3 ee_cs", ee_cs, m_cs);
      check1("R1/R2/R3 ee_sk", ee_sk, m_sk);
      check1("R1/R2/R3 ee_di", ee_di, m_di);
      check1("R6/R7 img_valid", img_valid, m_valid);
      check1("R8 img_pass", img_pass, m_pass);
    end
    check1("R4 cfg_rdata", cfg_rdata, exp_rd);
    check1("R5 cfg_pass_wr", cfg_pass_wr, exp_pw);
  end

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    step();
    cfg_wr = 1'b0; cfg_addr = 8'h10;
  endtask

  task automatic run_image(input logic [7:0] img [128], input int n);
    for (int i = 0; i < n; i++) begin
      img_word_vld = 1'b1;
      img_word = {img[2*i+1], img[2*i]};
      step();
    end
    img_word_vld = 1'b0;
  endtask

  task automatic do_start();
    img_start = 1'b1;
    step();
    img_start = 1'b0;
  endtask

  logic [7:0] img [128];

  task automatic build_default();
    int s;
    logic [15:0] ck;
    for (int i = 0; i < 128; i++) img[i] = 8'h00;
    for (int i = 0; i < 32; i += 2) img[i] = 8'h57;
    img[64] = 8'd7; img[65] = 8'h0F; img[67] = 8'd4; img[68] = 8'h07;
    s = 0;
    for (int i = 0; i < 126; i += 2) s += {img[i+1], img[i]};
    ck = 16'(32'h1234 - s);
    img[126] = ck[7:0];
    img[127] = ck[15:8];
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1 pin select with various bit patterns
    cfg_write(8'h80, 32'h0000_00C0);
    cfg_write(8'h80, 32'h0000_0080);
    cfg_write(8'h80, 32'hFFFF_FF3F);
    cfg_write(8'h80, 32'h0000_0040);
    // R3 unrelated writes hold the pins, R5 pass-through
    cfg_write(8'h04, 32'hFFFF_FFFF);
    cfg_write(8'h81, 32'h0000_0000);
    step();
    // R2 release
    cfg_write(8'hC0, 32'hFFFF_FFFF);
    cfg_write(8'h40, 32'h0000_00C0);
    // R4 read gating patterns
    cfg_addr = 8'h00; cfg_size = 3'd1; ee_do = 1'b0; step();
    ee_do = 1'b1; step();
    cfg_size = 3'd4; ee_do = 1'b0; step();
    cfg_size = 3'd2; step();
    cfg_addr = 8'h01; cfg_size = 3'd1; step();
    cfg_addr = 8'h00; cfg_dflt_rdata = 32'h0000_00FF; step();
    cfg_addr = 8'h10; cfg_size = 3'd4; ee_do = 1'b1;
    // R8 default image passes
    build_default();
    do_start();
    run_image(img, 64);
    step();
    // R7 surplus words ignored
    run_image(img, 3);
    step();
    // R8 corrupted image fails
    img[5] = img[5] ^ 8'h01;
    do_start();
    run_image(img, 64);
    step();
    // R6 restart midway: start drops concurrent word
    img[5] = img[5] ^ 8'h01;
    do_start();
    run_image(img, 20);
    img_start = 1'b1; img_word_vld = 1'b1; img_word = 16'hFFFF; step();
    img_start = 1'b0; img_word_vld = 1'b0;
    run_image(img, 64);
    step();
    // R6 wrap-around: all 0xFFFF words
    for (int i = 0; i < 128; i++) img[i] = 8'hFF;
    do_start();
    run_image(img, 64);
    step();
    // R6 gaps between words
    build_default();
    do_start();
    for (int i = 0; i < 64; i++) begin
      img_word_vld = 1'b1; img_word = {img[2*i+1], img[2*i]}; step();
      img_word_vld = 1'b0; step();
    end
    step();
    // R9 reset mid-run
    cfg_write(8'h80, 32'h0000_00C0);
    rst_n = 1'b0; step(); step();
    rst_n = 1'b1; repeat (4) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule